// File: doc/BRIEF.md
# Per-Processor Interrupt Claim Port

This block is the slice of a multiprocessor interrupt controller that sits beside one processor. It collects three kinds of interrupt sources: software-generated interrupts latched from the other processors, level lines private to this processor, and level lines already routed to it by a shared distributor. It keeps a per-interrupt enable bit and a per-interrupt active bit. Among the sources that are pending, enabled and not active, the lowest number wins and is reported to software.

Software drives the block through a small register port. Enables are changed by writing an interrupt number to a set register or to a clear register. A read of the claim register returns the winning number and marks it active as a side effect. A write of a number to the completion register releases it. A status register shows the current winner and carries a ready flag in bit 31, so a handler can keep claiming until the flag drops. A write to the send register emits a one-cycle software-interrupt request toward a set of target processors. The request line to the processor is raised while the port is enabled and something is ready.

Top module: `cpu_irq_port`

## Requirements
- R1: After synchronous reset, `irq_o`, `reg_rvalid_o`, `sgi_valid_o` and `reg_rdata_o` are 0, the control register reads 0, and every enable, active and software-pending bit is clear.
- R2: Bit 0 of the control register at offset 0x000 is written from `reg_wdata_i[0]` and reads back in bit 0.
- R3: Writing an interrupt number to offset 0x0A0 sets that interrupt's enable bit. A number of `NUM_IRQ` or more is ignored.
- R4: Writing an interrupt number to offset 0x0A4 clears that interrupt's enable bit.
- R5: An interrupt is ready when it is pending, enabled and not active. The lowest-numbered ready interrupt is the one reported.
- R6: A read of offset 0x0CLAIM (0x06C) returns the reported number in `reg_rdata_o` with `reg_rvalid_o` high one cycle after the read. The read marks that interrupt active, and it is not reported again until completed.
- R7: When nothing is ready, a claim read returns 0xFFFFFFFF and has no side effect, and the status register reads 0.
- R8: The status register at offset 0x068 returns the ready flag in bit 31 and the reported number in bits [IDW-1:0] (0 when not ready). Reading it has no side effect.
- R9: Writing an interrupt number to offset 0x0B4 clears its active bit. If the interrupt is still pending and enabled, it is reported again.
- R10: `irq_o` is 1 in the cycle after a cycle in which the control enable bit is 1 and some interrupt is ready, and 0 otherwise.
- R11: A write to offset 0x060 makes `sgi_valid_o` high for exactly the next cycle, with `sgi_id_o` = `reg_wdata_i[3:0]` and `sgi_mask_o` = `reg_wdata_i[15:8]`.
- R12: A pulse on `sgi_in_i[k]` latches interrupt k (0 to 15) as pending until it is claimed. After completion it is not reported again without a new pulse.
- R13: Interrupts 16 to 31 follow `priv_pend_i` and interrupts 32 to `NUM_IRQ`-1 follow `glob_pend_i` as levels, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sgi_in_i | input | N_SGI | Software-interrupt arrival pulses, one bit per number |
| priv_pend_i | input | N_LOCAL-N_SGI | Private level lines, interrupts 16 to 31 |
| glob_pend_i | input | NUM_IRQ-N_LOCAL | Distributed level lines, interrupts 32 and up |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register byte offset |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, registered |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Interrupt request to the processor |
| sgi_valid_o | output | 1 | Outgoing software-interrupt request pulse |
| sgi_id_o | output | 4 | Outgoing software-interrupt number |
| sgi_mask_o | output | NUM_CPU | Outgoing target-processor mask |

## Verification
Read data, `reg_rvalid_o` and the outgoing software-interrupt fields are due one clock after the strobe. The bench drives each strobe at a falling edge, drops it at the next falling edge, and samples the outputs there. Enable, active and latch changes take effect at the edge of the write and feed the winner combinationally, so a status or claim read issued in the next cycle already sees them. `irq_o` passes through one more register, so after changing the control bit or a source the bench waits two falling edges before sampling it.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_SEND  = 12'h060;
  localparam logic [11:0] OFS_STAT  = 12'h068;
  localparam logic [11:0] OFS_CLAIM = 12'h06C;
  localparam logic [11:0] OFS_SETEN = 12'h0A0;
  localparam logic [11:0] OFS_CLREN = 12'h0A4;
  localparam logic [11:0] OFS_DONE  = 12'h0B4;

  localparam logic [31:0] NONE_WORD = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    WOP_NONE,
    WOP_CTRL,
    WOP_SEND,
    WOP_SETEN,
    WOP_CLREN,
    WOP_DONE
  } wop_e;
endpackage

// File: rtl/cip_prio_enc.sv
module cip_prio_enc #(
  parameter int N   = 64,
  parameter int IDW = 6
) (
  input  logic [N-1:0]   req,
  output logic           found,
  output logic [IDW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/cip_src_state.sv
module cip_src_state #(
  parameter int NUM_IRQ = 64,
  parameter int N_SGI   = 16,
  parameter int IDW     = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic               done,
  input  logic [IDW-1:0]     wr_id,
  input  logic               claim,
  input  logic [IDW-1:0]     claim_id,
  input  logic [N_SGI-1:0]   sgi_hit,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] act_q,
  output logic [N_SGI-1:0]   sgi_q
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    logic wr_me;
    logic claim_me;
    assign wr_me    = (wr_id == IDW'(i));
    assign claim_me = claim && (claim_id == IDW'(i));

    always_ff @(posedge clk) begin
      if (rst)                  en_q[i] <= 1'b0;
      else if (set_en && wr_me) en_q[i] <= 1'b1;
      else if (clr_en && wr_me) en_q[i] <= 1'b0;
    end

    // claim wins over a completion of the same number in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                act_q[i] <= 1'b0;
      else if (claim_me)      act_q[i] <= 1'b1;
      else if (done && wr_me) act_q[i] <= 1'b0;
    end

    if (i < N_SGI) begin : g_sgi
      always_ff @(posedge clk) begin
        if (rst)             sgi_q[i] <= 1'b0;
        else if (sgi_hit[i]) sgi_q[i] <= 1'b1;
        else if (claim_me)   sgi_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
  import cip_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int N_LOCAL = 32,
  parameter int N_SGI   = 16,
  parameter int NUM_CPU = 8,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SGI-1:0]           sgi_in_i,
  input  logic [N_LOCAL-N_SGI-1:0]   priv_pend_i,
  input  logic [NUM_IRQ-N_LOCAL-1:0] glob_pend_i,
  input  logic                       reg_wr_i,
  input  logic                       reg_rd_i,
  input  logic [AW-1:0]              reg_addr_i,
  input  logic [DW-1:0]              reg_wdata_i,
  output logic [DW-1:0]              reg_rdata_o,
  output logic                       reg_rvalid_o,
  output logic                       irq_o,
  output logic                       sgi_valid_o,
  output logic [3:0]                 sgi_id_o,
  output logic [NUM_CPU-1:0]         sgi_mask_o
);
  localparam int IDW = $clog2(NUM_IRQ);

  logic               ctrl_en_q;
  logic [NUM_IRQ-1:0] en_q, act_q, pend_raw, ready;
  logic [N_SGI-1:0]   sgi_q;
  logic               hp_vld;
  logic [IDW-1:0]     hp_id;
  logic               id_ok;
  logic               claim_fire;
  wop_e               wop;
  logic [DW-1:0]      stat_word;

  // write decode
  always_comb begin
    wop = WOP_NONE;
    if (reg_wr_i) begin
      if      (reg_addr_i == AW'(OFS_CTRL))  wop = WOP_CTRL;
      else if (reg_addr_i == AW'(OFS_SEND))  wop = WOP_SEND;
      else if (reg_addr_i == AW'(OFS_SETEN)) wop = WOP_SETEN;
      else if (reg_addr_i == AW'(OFS_CLREN)) wop = WOP_CLREN;
      else if (reg_addr_i == AW'(OFS_DONE))  wop = WOP_DONE;
    end
  end

  assign id_ok      = (reg_wdata_i < DW'(NUM_IRQ));
  assign claim_fire = reg_rd_i && (reg_addr_i == AW'(OFS_CLAIM)) && hp_vld;

  cip_src_state #(
    .NUM_IRQ(NUM_IRQ),
    .N_SGI  (N_SGI),
    .IDW    (IDW)
  ) i_state (
    .clk     (clk),
    .rst     (rst),
    .set_en  ((wop == WOP_SETEN) && id_ok),
    .clr_en  ((wop == WOP_CLREN) && id_ok),
    .done    ((wop == WOP_DONE) && id_ok),
    .wr_id   (reg_wdata_i[IDW-1:0]),
    .claim   (claim_fire),
    .claim_id(hp_id),
    .sgi_hit (sgi_in_i),
    .en_q    (en_q),
    .act_q   (act_q),
    .sgi_q   (sgi_q)
  );

  assign pend_raw = {glob_pend_i, priv_pend_i, sgi_q};
  assign ready    = pend_raw & en_q & ~act_q;

  cip_prio_enc #(
    .N  (NUM_IRQ),
    .IDW(IDW)
  ) i_enc (
    .req  (ready),
    .found(hp_vld),
    .idx  (hp_id)
  );

  assign stat_word = {hp_vld, {(DW-1-IDW){1'b0}}, hp_id};

  // control bit and request line
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      if (wop == WOP_CTRL) ctrl_en_q <= reg_wdata_i[0];
      irq_o <= ctrl_en_q && hp_vld;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) begin
        if (reg_addr_i == AW'(OFS_CTRL))
          reg_rdata_o <= {{(DW-1){1'b0}}, ctrl_en_q};
        else if (reg_addr_i == AW'(OFS_STAT))
          reg_rdata_o <= stat_word;
        else if (reg_addr_i == AW'(OFS_CLAIM))
          reg_rdata_o <= hp_vld ? DW'(hp_id) : DW'(NONE_WORD);
        else
          reg_rdata_o <= '0;
      end
    end
  end

  // outgoing software interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      sgi_valid_o <= 1'b0;
      sgi_id_o    <= '0;
      sgi_mask_o  <= '0;
    end else begin
      sgi_valid_o <= (wop == WOP_SEND);
      if (wop == WOP_SEND) begin
        sgi_id_o   <= reg_wdata_i[3:0];
        sgi_mask_o <= reg_wdata_i[8 +: NUM_CPU];
      end
    end
  end
endmodule

// File: rtl/cpu_irq_port_chk.sv
module cpu_irq_port_chk #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int IDW     = 6,
  parameter int NUM_CPU = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rd_i,
  input logic               reg_wr_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic               reg_rvalid_o,
  input logic               irq_o,
  input logic               sgi_valid_o,
  input logic [3:0]         sgi_id_o,
  input logic [NUM_CPU-1:0] sgi_mask_o,
  input logic               ctrl_en_q,
  input logic               hp_vld,
  input logic [IDW-1:0]     hp_id
);
  logic rd_claim, wr_send;
  assign rd_claim = reg_rd_i && (reg_addr_i == AW'(12'h06C));
  assign wr_send  = reg_wr_i && (reg_addr_i == AW'(12'h060));

  p_rvalid_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rvalid_o);

  p_claim_value_r6: assert property (@(posedge clk) disable iff (rst)
    rd_claim && hp_vld |=> reg_rdata_o == DW'($past(hp_id)));

  p_claim_not_again_r6: assert property (@(posedge clk) disable iff (rst)
    rd_claim && hp_vld |=> !(hp_vld && hp_id == $past(hp_id)));

  p_empty_sentinel_r7: assert property (@(posedge clk) disable iff (rst)
    rd_claim && !hp_vld |=> reg_rdata_o == {DW{1'b1}});

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_en_q) && $past(hp_vld));

  p_send_fields_r11: assert property (@(posedge clk) disable iff (rst)
    wr_send |=> sgi_valid_o && sgi_id_o == $past(reg_wdata_i[3:0])
                && sgi_mask_o == $past(reg_wdata_i[8 +: NUM_CPU]));

  p_send_only_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_send |=> !sgi_valid_o);
endmodule

bind cpu_irq_port cpu_irq_port_chk #(
  .AW     (AW),
  .DW     (DW),
  .IDW    (IDW),
  .NUM_CPU(NUM_CPU)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_rvalid_o(reg_rvalid_o),
  .irq_o       (irq_o),
  .sgi_valid_o (sgi_valid_o),
  .sgi_id_o    (sgi_id_o),
  .sgi_mask_o  (sgi_mask_o),
  .ctrl_en_q   (ctrl_en_q),
  .hp_vld      (hp_vld),
  .hp_id       (hp_id)
);

// File: tb/test_cpu_irq_port.sv
module test_cpu_irq_port;
  localparam int NUM_IRQ = 64;
  localparam int N_LOCAL = 32;
  localparam int N_SGI   = 16;
  localparam int NUM_CPU = 8;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic [N_SGI-1:0]           sgi_in = '0;
  logic [N_LOCAL-N_SGI-1:0]   priv = '0;
  logic [NUM_IRQ-N_LOCAL-1:0] glob = '0;
  logic                       wr = 1'b0, rd = 1'b0;
  logic [11:0]                addr = '0;
  logic [31:0]                wdata = '0;
  logic [31:0]                rdata;
  logic                       rvalid, irq, sgi_v;
  logic [3:0]                 sgi_id;
  logic [NUM_CPU-1:0]         sgi_mask;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cpu_irq_port i_cpu_irq_port (
    .clk(clk), .rst(rst), .sgi_in_i(sgi_in), .priv_pend_i(priv),
    .glob_pend_i(glob), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .irq_o(irq), .sgi_valid_o(sgi_v), .sgi_id_o(sgi_id), .sgi_mask_o(sgi_mask)
  );

  // vector: {is_read, req, offset, wdata, expected}
  localparam int NV = 25;
  localparam bit [80:0] VEC [NV] = '{
    {1'b1, 4'd7,  12'h06C, 32'd0,   32'hFFFF_FFFF}, // R7 nothing enabled
    {1'b1, 4'd7,  12'h068, 32'd0,   32'h0},
    {1'b0, 4'd3,  12'h0A0, 32'd100, 32'h0},         // R3 out of range
    {1'b1, 4'd3,  12'h068, 32'd0,   32'h0},
    {1'b0, 4'd3,  12'h0A0, 32'd40,  32'h0},
    {1'b0, 4'd3,  12'h0A0, 32'd33,  32'h0},
    {1'b1, 4'd5,  12'h068, 32'd0,   32'h8000_0021}, // R5 lowest wins
    {1'b1, 4'd6,  12'h06C, 32'd0,   32'd33},
    {1'b1, 4'd6,  12'h068, 32'd0,   32'h8000_0028}, // R6 33 now active
    {1'b1, 4'd6,  12'h06C, 32'd0,   32'd40},
    {1'b1, 4'd7,  12'h06C, 32'd0,   32'hFFFF_FFFF},
    {1'b0, 4'd9,  12'h0B4, 32'd33,  32'h0},
    {1'b1, 4'd9,  12'h06C, 32'd0,   32'd33},        // R9 re-reported
    {1'b0, 4'd4,  12'h0A4, 32'd40,  32'h0},
    {1'b0, 4'd9,  12'h0B4, 32'd40,  32'h0},
    {1'b0, 4'd9,  12'h0B4, 32'd33,  32'h0},
    {1'b1, 4'd4,  12'h06C, 32'd0,   32'd33},
    {1'b1, 4'd4,  12'h068, 32'd0,   32'h0},         // R4 40 disabled
    {1'b0, 4'd9,  12'h0B4, 32'd33,  32'h0},
    {1'b0, 4'd13, 12'h0A0, 32'd20,  32'h0},
    {1'b1, 4'd13, 12'h06C, 32'd0,   32'd20},        // R13 private line
    {1'b0, 4'd9,  12'h0B4, 32'd20,  32'h0},
    {1'b0, 4'd4,  12'h0A4, 32'd20,  32'h0},
    {1'b0, 4'd4,  12'h0A4, 32'd33,  32'h0},
    {1'b1, 4'd8,  12'h068, 32'd0,   32'h0}          // R8 nothing left
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    check(req, {31'b0, rvalid}, 32'd1);
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(1, {28'b0, irq, rvalid, sgi_v, 1'b0}, 32'h0);
    check(1, rdata, 32'h0);
    rd_reg(12'h000, 32'h0, 1);

    // table walk: ids 33,36,40 distributed, id 20 private
    glob = '0; glob[1] = 1'b1; glob[4] = 1'b1; glob[8] = 1'b1;
    priv = '0; priv[4] = 1'b1;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][80]) rd_reg(VEC[v][75:64], VEC[v][31:0], int'(VEC[v][79:76]));
      else            wr_reg(VEC[v][75:64], VEC[v][63:32]);
    end
    glob = '0; priv = '0;

    // R2 control bit
    wr_reg(12'h000, 32'h1);
    rd_reg(12'h000, 32'h1, 2);

    // R10 request line
    repeat (2) @(negedge clk);
    check(10, {31'b0, irq}, 32'd0);
    priv[4] = 1'b1;
    wr_reg(12'h0A0, 32'd20);
    @(negedge clk);
    check(10, {31'b0, irq}, 32'd1);
    wr_reg(12'h000, 32'h0);
    @(negedge clk);
    check(10, {31'b0, irq}, 32'd0);
    wr_reg(12'h000, 32'h1);
    wr_reg(12'h0A4, 32'd20);
    priv = '0;
    repeat (2) @(negedge clk);
    check(10, {31'b0, irq}, 32'd0);

    // R11 outgoing software interrupt
    wr_reg(12'h060, 32'h0000_A50F);
    check(11, {23'b0, sgi_v, sgi_mask}, {23'b0, 1'b1, 8'hA5});
    check(11, {28'b0, sgi_id}, 32'hF);
    @(negedge clk);
    check(11, {31'b0, sgi_v}, 32'd0);

    // R12 incoming software interrupt latch
    @(negedge clk);
    sgi_in[15] = 1'b1;
    @(negedge clk);
    sgi_in = '0;
    wr_reg(12'h0A0, 32'd15);
    rd_reg(12'h068, 32'h8000_000F, 12);
    rd_reg(12'h06C, 32'd15, 12);
    wr_reg(12'h0B4, 32'd15);
    rd_reg(12'h06C, 32'hFFFF_FFFF, 12);

    // R13 level drop
    glob[1] = 1'b1;
    wr_reg(12'h0A0, 32'd33);
    rd_reg(12'h068, 32'h8000_0021, 13);
    glob = '0;
    rd_reg(12'h068, 32'h0, 13);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule